// File: doc/BRIEF.md
# Burst Read Target with Word Table

This block is the read side of a memory-mapped target that uses the AXI4 read channels. A single request arrives on the read-address channel. The request carries an ID, a start address, a beat count minus one, a beat size and a burst kind. The block takes in one request at a time. It then plays the whole burst back on the read-data channel. Every beat carries a data word, a two-bit status, the echoed ID and an end-of-burst flag.

Beat addresses come from an internal generator. The generator steps the address according to the burst kind: it holds the address, counts it upward, or wraps it inside an aligned window. The backing store is a small table of words. Addresses that map past the table end get an error status and a zero data word.

A two-state controller sequences the block. It waits for a request in `ST_WAIT_REQ`. It moves to `ST_SEND_BEAT` on the transition named *accept*, which is a request handshake. It returns to `ST_WAIT_REQ` on the transition named *finish*, which is the handshake of the beat marked last. While in `ST_SEND_BEAT`, the transition named *advance* keeps the state, steps the address and steps the beat counter. Advance fires on a handshake of a beat that is not last.

Top module: `axi_burst_rd_resp`

## Requirements
- R1: After reset is released, `arready` is 1 and `rvalid` is 0.
- R2: A request is taken only on a rising clock edge where `arvalid` and `arready` are both 1. Exactly `arlen`+1 beats follow it, and the first beat is presented in the cycle after acceptance.
- R3: A beat completes only on an edge where `rvalid` and `rready` are both 1. While `rvalid` is 1 and `rready` is 0, `rdata`, `rresp`, `rid` and `rlast` hold their values.
- R4: `rlast` is 1 on the final beat of a burst and 0 on every other beat.
- R5: `rid` on every beat equals the `arid` captured when the request was accepted.
- R6: `arready` stays 0 from request acceptance until the beat with `rlast` has transferred, so `arready` and `rvalid` are never 1 together.
- R7: Burst kind 2'b00 (hold) gives every beat the start address.
- R8: Burst kind 2'b01 (count up) gives the first beat the start address. Each later beat is the previous address aligned down to the beat size, plus 2^`arsize` bytes. Word k of the table reads as INIT_BASE + k, which is 32'h10 + k by default. For example, 4 beats of 4 bytes from address 0 read addresses 0x0, 0x4, 0x8 and 0xC and return 0x10, 0x11, 0x12 and 0x13.
- R9: Burst kind 2'b10 (wrap) steps addresses like kind 2'b01 inside a window of 2^`arsize` × (`arlen`+1) bytes aligned to its own size. An address that passes the window top returns to the window base.
- R10: A beat whose word index (the address divided by 4) is DEPTH (16) or above returns status 2'b10 with data 0. In-range beats return status 2'b00 and the table word.
- R11: Burst kind 2'b11 still returns `arlen`+1 beats, and every beat has status 2'b10 and data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| arvalid | input | 1 | Request present |
| arready | output | 1 | Block can take a request |
| arid | input | ID_W | Request ID |
| araddr | input | ADDR_W | Byte address of the first beat |
| arlen | input | LEN_W | Beat count minus one |
| arsize | input | 3 | Log2 of bytes per beat |
| arburst | input | 2 | Burst kind: 00 hold, 01 count up, 10 wrap, 11 reserved |
| rvalid | output | 1 | Beat present |
| rready | input | 1 | Initiator takes the beat |
| rid | output | ID_W | ID echoed from the request |
| rdata | output | DATA_W | Beat data |
| rresp | output | 2 | Beat status: 00 okay, 10 error |
| rlast | output | 1 | Final beat of the burst |

## Verification
The bench sends a wrapping burst that starts mid-window. A generator that never wraps would run past the window into the next words. It also sends a count-up burst that crosses the table end, which catches a range check that is off by one word or that errors the whole burst instead of single beats. The bench applies irregular ready stalls and issues a second request while the first burst is still active. A design that steps its address on a stalled cycle, or that takes a request early, drifts from the reference queue. Single-beat, two-byte and reserved-kind bursts complete the set; they expose a last flag tied to the wrong count, misaligned stepping, and a reserved kind that reports okay.

// File: rtl/burst_rd_pkg.sv
package burst_rd_pkg;

    typedef enum logic [1:0] {
        BT_FIXED = 2'b00,
        BT_INCR  = 2'b01,
        BT_WRAP  = 2'b10,
        BT_RSVD  = 2'b11
    } burst_kind_e;

    typedef enum logic {
        ST_WAIT_REQ  = 1'b0,
        ST_SEND_BEAT = 1'b1
    } rd_state_e;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;

endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_rd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [2:0]        beat_size,
    input  logic [LEN_W-1:0]  beat_len,
    input  burst_kind_e       kind,
    output logic [ADDR_W-1:0] next_addr
);

    logic [ADDR_W-1:0] step_bytes;
    logic [ADDR_W-1:0] step_mask;
    logic [ADDR_W-1:0] aligned;
    logic [ADDR_W-1:0] window;
    logic [ADDR_W-1:0] win_mask;
    logic [ADDR_W-1:0] stepped;

    always_comb begin
        step_bytes = ADDR_W'(1) << beat_size;
        step_mask  = step_bytes - ADDR_W'(1);
        aligned    = cur_addr & ~step_mask;
        stepped    = aligned + step_bytes;
        window     = step_bytes * (ADDR_W'(beat_len) + ADDR_W'(1));
        win_mask   = window - ADDR_W'(1);
        unique case (kind)
            BT_INCR: next_addr = stepped;
            BT_WRAP: next_addr = (cur_addr & ~win_mask) | (stepped & win_mask);
            default: next_addr = cur_addr;
        endcase
    end

endmodule

// File: rtl/rd_word_store.sv
module rd_word_store
    import burst_rd_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 16,
    parameter int DEPTH     = 16,
    parameter int INIT_BASE = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] word,
    output logic [1:0]        status
);

    localparam int BYTES = DATA_W / 8;
    localparam int OFS   = $clog2(BYTES);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] table_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        assign table_q[g] = DATA_W'(INIT_BASE + g);
    end

    logic [ADDR_W-1:0] word_idx;
    logic [IDX_W-1:0]  sel;
    logic              hit;

    always_comb begin
        word_idx = addr >> OFS;
        hit      = word_idx < ADDR_W'(DEPTH);
        sel      = word_idx[IDX_W-1:0];
        word     = hit ? table_q[sel] : '0;
        status   = hit ? RESP_OKAY : RESP_SLVERR;
    end

endmodule

// File: rtl/axi_burst_rd_resp.sv
module axi_burst_rd_resp
    import burst_rd_pkg::*;
#(
    parameter int ID_W      = 4,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int LEN_W     = 8,
    parameter int DEPTH     = 16,
    parameter int INIT_BASE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arvalid,
    output logic              arready,
    input  logic [ID_W-1:0]   arid,
    input  logic [ADDR_W-1:0] araddr,
    input  logic [LEN_W-1:0]  arlen,
    input  logic [2:0]        arsize,
    input  logic [1:0]        arburst,
    output logic              rvalid,
    input  logic              rready,
    output logic [ID_W-1:0]   rid,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rlast
);

    rd_state_e         state, nxt_state;
    logic [ID_W-1:0]   id_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [2:0]        size_q;
    burst_kind_e       kind_q;

    logic              accept;
    logic              beat_done;
    logic              final_beat;
    logic [ADDR_W-1:0] step_addr;
    logic [DATA_W-1:0] store_word;
    logic [1:0]        store_status;

    assign accept     = arvalid && arready;
    assign beat_done  = rvalid && rready;
    assign final_beat = (cnt_q == len_q);

    burst_addr_gen #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_addr_gen (
        .cur_addr  (addr_q),
        .beat_size (size_q),
        .beat_len  (len_q),
        .kind      (kind_q),
        .next_addr (step_addr)
    );

    rd_word_store #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .DEPTH     (DEPTH),
        .INIT_BASE (INIT_BASE)
    ) u_store (
        .addr   (addr_q),
        .word   (store_word),
        .status (store_status)
    );

    // next-state: accept, advance (stay), finish
    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_WAIT_REQ:  if (accept) nxt_state = ST_SEND_BEAT;
            ST_SEND_BEAT: if (beat_done && final_beat) nxt_state = ST_WAIT_REQ;
            default:      nxt_state = ST_WAIT_REQ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WAIT_REQ;
        else        state <= nxt_state;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q   <= '0;
            addr_q <= '0;
            len_q  <= '0;
            cnt_q  <= '0;
            size_q <= '0;
            kind_q <= BT_FIXED;
        end else if (accept) begin
            id_q   <= arid;
            addr_q <= araddr;
            len_q  <= arlen;
            cnt_q  <= '0;
            size_q <= arsize;
            kind_q <= burst_kind_e'(arburst);
        end else if (beat_done && !final_beat) begin
            addr_q <= step_addr;
            cnt_q  <= cnt_q + LEN_W'(1);
        end
    end

    always_comb begin
        arready = 1'b0;
        rvalid  = 1'b0;
        unique case (state)
            ST_WAIT_REQ:  arready = 1'b1;
            ST_SEND_BEAT: rvalid  = 1'b1;
            default:      arready = 1'b0;
        endcase
        rid   = id_q;
        rlast = rvalid && final_beat;
        if (kind_q == BT_RSVD) begin
            rdata = '0;
            rresp = RESP_SLVERR;
        end else begin
            rdata = rvalid ? store_word : '0;
            rresp = store_status;
        end
    end

endmodule

// File: rtl/burst_rd_checker.sv
module burst_rd_checker #(
    parameter int ID_W   = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arvalid,
    input logic              arready,
    input logic [ID_W-1:0]   arid,
    input logic              rvalid,
    input logic              rready,
    input logic [ID_W-1:0]   rid,
    input logic [DATA_W-1:0] rdata,
    input logic [1:0]        rresp,
    input logic              rlast
);

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> arready && !rvalid);

    a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(arready && rvalid));

    a_r2_beat_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        arvalid && arready |=> rvalid);

    a_r3_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && !rready |=> rvalid && $stable(rdata) && $stable(rresp)
                              && $stable(rid) && $stable(rlast));

    a_r4_last_ends_burst: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && rready && rlast |=> !rvalid);

    a_r5_id_capture: assert property (@(posedge clk) disable iff (!rst_n)
        arvalid && arready |=> rid == $past(arid));

    a_r10_error_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && rresp == 2'b10 |-> rdata == '0);

endmodule

bind axi_burst_rd_resp burst_rd_checker #(
    .ID_W   (ID_W),
    .DATA_W (DATA_W)
) u_burst_rd_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .arvalid (arvalid),
    .arready (arready),
    .arid    (arid),
    .rvalid  (rvalid),
    .rready  (rready),
    .rid     (rid),
    .rdata   (rdata),
    .rresp   (rresp),
    .rlast   (rlast)
);

// File: tb/tb_axi_burst_rd_resp.sv
module tb_axi_burst_rd_resp;

    localparam int CLK_PERIOD = 10;
    localparam int ID_W = 4, ADDR_W = 16, DATA_W = 32, LEN_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              arvalid = 1'b0;
    logic              arready;
    logic [ID_W-1:0]   arid = '0;
    logic [ADDR_W-1:0] araddr = '0;
    logic [LEN_W-1:0]  arlen = '0;
    logic [2:0]        arsize = '0;
    logic [1:0]        arburst = '0;
    logic              rvalid;
    logic              rready = 1'b0;
    logic [ID_W-1:0]   rid;
    logic [DATA_W-1:0] rdata;
    logic [1:0]        rresp;
    logic              rlast;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int rdy_mode = 0;
    logic [7:0] lfsr = 8'hA5;
    bit model_on = 0;

    int q_data[$];
    int q_resp[$];
    int q_id[$];
    int q_last[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    axi_burst_rd_resp dut (
        .clk(clk), .rst_n(rst_n),
        .arvalid(arvalid), .arready(arready), .arid(arid), .araddr(araddr),
        .arlen(arlen), .arsize(arsize), .arburst(arburst),
        .rvalid(rvalid), .rready(rready), .rid(rid), .rdata(rdata),
        .rresp(rresp), .rlast(rlast)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference: expand one request into its beats
    task automatic load_expected(input int id, input int addr, input int len,
                                 input int size, input int kind);
        int bytes = 1 << size;
        int wl = bytes * (len + 1);
        for (int i = 0; i <= len; i++) begin
            int a;
            if (kind == 0)      a = addr;
            else if (kind == 1) a = (i == 0) ? addr : ((addr / bytes) * bytes + i * bytes);
            else                a = (addr / wl) * wl + ((addr + i * bytes) % wl);
            if (kind == 3 || a >= 64) begin
                q_data.push_back(0);
                q_resp.push_back(2);
            end else begin
                q_data.push_back(16 + a / 4);
                q_resp.push_back(0);
            end
            q_id.push_back(id);
            q_last.push_back(i == len ? 1 : 0);
        end
    endtask

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && model_on) begin
            chk(arready == (q_data.size() == 0), "R6 arready", int'(arready), int'(q_data.size() == 0));
            chk(rvalid == (q_data.size() != 0), "R2 rvalid", int'(rvalid), int'(q_data.size() != 0));
            if (rvalid && q_data.size() != 0) begin
                chk(rdata == q_data[0], "R8/R10 rdata", int'(rdata), q_data[0]);
                chk(rresp == q_resp[0], "R10/R11 rresp", int'(rresp), q_resp[0]);
                chk(rid == q_id[0], "R5 rid", int'(rid), q_id[0]);
                chk(rlast == q_last[0], "R4 rlast", int'(rlast), q_last[0]);
            end
            if (rvalid && rready && q_data.size() != 0) begin
                void'(q_data.pop_front()); void'(q_resp.pop_front());
                void'(q_id.pop_front());   void'(q_last.pop_front());
            end else if (arvalid && arready) begin
                load_expected(int'(arid), int'(araddr), int'(arlen), int'(arsize), int'(arburst));
            end
        end
    end

    // rready pattern driver (R3 stalls)
    initial begin
        forever begin
            @(posedge clk); #1;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            case (rdy_mode)
                0: rready = 1'b1;
                1: rready = cycles[0];
                default: rready = lfsr[0];
            endcase
        end
    end

    task automatic issue(input int id, input int addr, input int len,
                         input int size, input int kind);
        bit took;
        @(posedge clk); #1;
        arvalid = 1'b1; arid = ID_W'(id); araddr = ADDR_W'(addr);
        arlen = LEN_W'(len); arsize = 3'(size); arburst = 2'(kind);
        forever begin
            @(negedge clk); took = arready;
            @(posedge clk); #1;
            if (took) break;
        end
        arvalid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (q_data.size() != 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000) begin
                total++; bad++;
                $display("FAIL watchdog R2 actual=%0d expected=<50000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(arready == 1'b1, "R1 arready after reset", int'(arready), 1);
        chk(rvalid == 1'b0, "R1 rvalid after reset", int'(rvalid), 0);
        model_on = 1;

        rdy_mode = 0;
        issue(3, 'h00, 3, 2, 1); wait_idle();          // R8 worked example
        rdy_mode = 1;
        issue(5, 'h14, 2, 2, 0); wait_idle();          // R7 hold
        rdy_mode = 2;
        issue(9, 'h28, 3, 2, 2); wait_idle();          // R9 mid-window wrap
        rdy_mode = 1;
        issue(2, 'h38, 3, 2, 1); wait_idle();          // R10 crosses table end
        issue(6, 'h00, 1, 2, 3); wait_idle();          // R11 reserved kind
        rdy_mode = 0;
        issue(15, 'h3C, 0, 2, 1); wait_idle();         // R4 single beat
        issue(7, 'h0C, 1, 2, 2); wait_idle();          // R9 two-beat wrap
        rdy_mode = 2;
        issue(1, 'h02, 3, 1, 1); wait_idle();          // R8 two-byte beats
        issue(4, 'h10, 7, 2, 1);                       // R6 second request pending
        issue(12, 'h20, 15, 2, 2); wait_idle();        // R9 16-beat wrap
        issue(8, 'h100, 2, 2, 0); wait_idle();         // R10 far out of range

        chk(arready == 1'b1, "R6 idle after last beat", int'(arready), 1);
        finish_run();
    end

endmodule